// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running calendar time (seconds, minutes, hours, weekday, day of month and month) and raises a sticky alarm flag when the time reaches a programmed alarm setting. Each of the six alarm registers holds a compare-enable bit next to a 7-bit BCD value. Any subset of fields can be left out of the comparison. For example, enabling only minutes and seconds gives an alarm that fires once per hour.

The comparison is qualified by a once-per-second strobe from the calendar counter, which is outside this block. The alarm flag sets on the edge after a strobe cycle in which every enabled field matches. It stays set until software clears it. A level-sensitive interrupt line follows the flag, gated by an interrupt enable bit. Software programs the alarm registers and the control register through a simple write port with a combinational read-back port.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: Addresses 0 to 5 select the alarm registers for seconds, minutes, hours, weekday, day of month and month, in that order. In each, bit 7 is the compare enable and bits 6:0 are the BCD value. A write stores all 8 bits, and a read of the same address returns them from the next cycle.
- R2: A field whose enable bit is 0 takes no part in the comparison, whatever its value bits hold. Writing 0 to an alarm register disables that field.
- R3: While no field is enabled, a seconds strobe never sets the alarm flag.
- R4: On a cycle with the strobe high, if every enabled alarm value equals its time field, the flag is 1 from the next clock edge. Time field k is cur_time_i[7k+6:7k], with k in the same order as the addresses. The flag does not set on a cycle without the strobe.
- R5: Once set, the flag stays set until software clears it, whatever the time inputs and the strobe do.
- R6: Address 6 is the control register, with the alarm flag in bit 0 and the interrupt enable in bit 3. Writing 0 to bit 0 clears the flag. Writing 1 to bit 0 leaves the flag unchanged. Bit 3 takes the written value. All other bits read as 0.
- R7: irq_o is high exactly while the flag and the interrupt enable are both 1, as a level.
- R8: When a hardware set and a software clear of the flag fall in the same cycle, the flag ends up set.
- R9: After reset, every alarm register and the control register read 0 and irq_o is low. Address 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds strobe from the calendar counter |
| cur_time_i | input | 42 | Current BCD time, six 7-bit fields, seconds in the low bits |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
Writes, strobe matches and flag clears all take effect at the clock edge that samples them. Read data and irq_o come from registers through combinational logic only. Their new values are therefore due one cycle after the stimulus. Read data is due immediately for the address currently driven. The bench drives every input at the falling edge and checks read data and irq_o 1 ns later. It compares them against a model state that it updates only after each rising edge. As a result, each check sees exactly the effect of the previous cycle's stimulus. The model computes a match from the alarm values held before any write in the same cycle, as the registered design does.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int VAL_W      = 7;
  localparam int REG_W      = VAL_W + 1;
  localparam int ADDR_W     = 3;
  localparam int TIME_W     = NUM_FIELDS * VAL_W;
  localparam int CTRL_ADDR  = NUM_FIELDS;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;

  typedef enum logic [ADDR_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    REG_CTRL = 3'd6,
    REG_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg #(
  parameter int REG_W = 8,
  parameter int VAL_W = REG_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             en_o,
  output logic [VAL_W-1:0] val_o,
  output logic [REG_W-1:0] raw_o
);
  logic [REG_W-1:0] fld_q, fld_d;

  always_comb begin
    fld_d = fld_q;
    if (wr_en_i) fld_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fld_q <= '0;
    else if (wr_en_i) fld_q <= fld_d;
  end

  assign en_o  = fld_q[REG_W-1];
  assign val_o = fld_q[VAL_W-1:0];
  assign raw_o = fld_q;

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> raw_o == $past(wdata_i));
  a_r2_zero_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i == '0) |=> !en_o);
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NUM_FIELDS = 6,
  parameter int VAL_W      = 7,
  localparam int TIME_W    = NUM_FIELDS * VAL_W
) (
  input  logic [NUM_FIELDS-1:0] en_i,
  input  logic [TIME_W-1:0]     alarm_i,
  input  logic [TIME_W-1:0]     now_i,
  output logic                  hit_o
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    logic eq;
    assign eq          = (alarm_i[k*VAL_W +: VAL_W] == now_i[k*VAL_W +: VAL_W]);
    assign field_ok[k] = eq | ~en_i[k];
  end

  assign hit_o = (&field_ok) & (|en_i);

  always_comb begin
    if (en_i == '0) begin
      a_r3_idle_no_hit: assert (!hit_o);
    end
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl #(
  parameter int REG_W    = 8,
  parameter int FLAG_BIT = 0,
  parameter int IE_BIT   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             flag_o,
  output logic             ie_o,
  output logic             irq_o
);
  logic flag_q, flag_d;
  logic ie_q, ie_d;
  logic sw_clr;

  assign sw_clr = ctrl_we_i & ~wdata_i[FLAG_BIT];

  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    if (set_i)       flag_d = 1'b1;
    else if (sw_clr) flag_d = 1'b0;
    if (ctrl_we_i)   ie_d   = wdata_i[IE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (ctrl_we_i) ie_q <= ie_d;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q & ie_q;

  a_r4_set_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !sw_clr) |=> flag_o);
  a_r4_no_set_without_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
  a_r6_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr && !set_i) |=> !flag_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr && set_i) |=> flag_o);
  a_r7_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_o |-> !irq_o);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] cur_time_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NUM_FIELDS-1:0]            fld_en;
  logic [TIME_W-1:0]                fld_val;
  logic [NUM_FIELDS-1:0][REG_W-1:0] fld_raw;
  logic                             hit;
  logic                             flag;
  logic                             ie;
  logic                             ctrl_we;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    logic wr_k;
    assign wr_k = we_i && (addr_i == ADDR_W'(k));
    alarm_field_reg #(.REG_W(REG_W), .VAL_W(VAL_W)) u_fld (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_k),
      .wdata_i (wdata_i),
      .en_o    (fld_en[k]),
      .val_o   (fld_val[k*VAL_W +: VAL_W]),
      .raw_o   (fld_raw[k])
    );
  end

  alarm_match #(.NUM_FIELDS(NUM_FIELDS), .VAL_W(VAL_W)) u_match (
    .en_i    (fld_en),
    .alarm_i (fld_val),
    .now_i   (cur_time_i),
    .hit_o   (hit)
  );

  assign ctrl_we = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

  alarm_ctrl #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (tick_i & hit),
    .ctrl_we_i (ctrl_we),
    .wdata_i   (wdata_i),
    .flag_o    (flag),
    .ie_o      (ie),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < NUM_FIELDS) begin
      rdata_o = fld_raw[addr_i];
    end else if (int'(addr_i) == CTRL_ADDR) begin
      rdata_o[FLAG_BIT] = flag;
      rdata_o[IE_BIT]   = ie;
    end
  end

  a_r9_unused_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd7) |-> rdata_o == '0);
  a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rdata_o[FLAG_BIT] || int'(addr_i) != CTRL_ADDR);
endmodule

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        tick_i;
  logic [41:0] cur_time_i;
  logic        we_i;
  logic [2:0]  addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_al [6];
  logic       m_flag, m_ie;

  always #2 clk_i = ~clk_i;

  bcd_alarm_cmp u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cur_time_i(cur_time_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic model_hit(logic [41:0] t);
    logic any = 1'b0;
    logic ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (m_al[k][7]) begin
        any = 1'b1;
        if (m_al[k][6:0] != t[k*7 +: 7]) ok = 1'b0;
      end
    end
    return any & ok;
  endfunction

  function automatic logic [7:0] model_read(logic [2:0] a);
    if (a < 3'd6) return m_al[a];
    if (a == 3'd6) return {4'b0, m_ie, 2'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check pre-edge state, advance model after posedge.
  task automatic cycle(input logic tk, input logic [41:0] t, input logic w,
                       input logic [2:0] a, input logic [7:0] d, input string req);
    logic set;
    @(negedge clk_i);
    tick_i = tk; cur_time_i = t; we_i = w; addr_i = a; wdata_i = d;
    #1;
    check(rdata_o, model_read(a), req);
    check({7'b0, irq_o}, {7'b0, m_flag & m_ie}, "R7");
    set = tk & model_hit(t);
    @(posedge clk_i);
    if (w && a < 3'd6) m_al[a] = d;
    if (w && a == 3'd6) m_ie = d[3];
    if (set) m_flag = 1'b1;
    else if (w && a == 3'd6 && !d[0]) m_flag = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
    cycle(1'b0, cur_time_i, 1'b1, a, d, req);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cycle(1'b0, cur_time_i, 1'b0, a, 8'h00, req);
  endtask

  function automatic logic [41:0] time_of(logic [6:0] s, logic [6:0] mi, logic [6:0] h,
                                          logic [6:0] wd, logic [6:0] md, logic [6:0] mo);
    return {mo, md, wd, h, mi, s};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [41:0] t;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; tick_i = 0; cur_time_i = '0; we_i = 0; addr_i = 0; wdata_i = 0;
    for (int k = 0; k < 6; k++) m_al[k] = 8'h00;
    m_flag = 0; m_ie = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    // R9: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R9");

    // R1: write/readback every field
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h80 | 8'(a * 5 + 1), "R1");
    for (int a = 0; a < 6; a++) rd(3'(a), "R1");

    // R2: all fields disabled by writing 0, R3: ticks never set the flag
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00, "R2");
    cycle(1'b1, '0, 1'b0, 3'd6, 8'h00, "R3");
    cycle(1'b1, '0, 1'b0, 3'd6, 8'h00, "R3");
    rd(3'd6, "R3");

    // R6: enable interrupt; write 1 to flag bit does not set it
    wr(3'd6, 8'h09, "R6");
    rd(3'd6, "R6");

    // R4: seconds only match 0x30; no tick -> no set; tick -> set
    wr(3'd0, 8'hB0, "R1");
    t = time_of(7'h30, 7'h12, 7'h05, 7'h02, 7'h17, 7'h09);
    cycle(1'b0, t, 1'b0, 3'd6, 8'h00, "R4");
    rd(3'd6, "R4");
    cycle(1'b1, t, 1'b0, 3'd6, 8'h00, "R4");
    rd(3'd6, "R4");
    // R5: sticky under mismatching ticks
    cycle(1'b1, time_of(7'h31, 7'h12, 7'h05, 7'h02, 7'h17, 7'h09), 1'b0, 3'd6, 8'h00, "R5");
    rd(3'd6, "R5");
    // R7: ie off drops irq, flag stays
    wr(3'd6, 8'h01, "R7");
    rd(3'd6, "R7");
    wr(3'd6, 8'h08, "R6");
    rd(3'd6, "R6");

    // R2: disabled month field with mismatching value ignored
    wr(3'd5, 8'h12, "R2");
    cycle(1'b1, t, 1'b0, 3'd6, 8'h00, "R2");
    rd(3'd6, "R2");
    // R8: set and clear in same cycle
    cycle(1'b1, t, 1'b1, 3'd6, 8'h08, "R8");
    rd(3'd6, "R8");
    // month enabled at 12, time month 9 -> no set after clear
    wr(3'd6, 8'h08, "R6");
    wr(3'd5, 8'h92, "R1");
    cycle(1'b1, t, 1'b0, 3'd6, 8'h00, "R4");
    rd(3'd6, "R4");
    t[41:35] = 7'h12;
    cycle(1'b1, t, 1'b0, 3'd6, 8'h00, "R4");
    rd(3'd6, "R4");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [41:0] rt;
      int op;
      for (int k = 0; k < 6; k++)
        rt[k*7 +: 7] = ($urandom_range(0, 2) != 0) ? m_al[k][6:0] : 7'($urandom_range(0, 89));
      op = $urandom_range(0, 9);
      if (op < 2)
        cycle(1'($urandom_range(0, 1)), rt, 1'b1, 3'($urandom_range(0, 5)),
              {1'($urandom_range(0, 3) != 0), 7'($urandom_range(0, 40))}, "R1");
      else if (op == 2)
        cycle(1'($urandom_range(0, 1)), rt, 1'b1, 3'd6, 8'($urandom), "R6");
      else
        cycle(1'($urandom_range(0, 3) == 0), rt, 1'b0, 3'($urandom_range(0, 7)), 8'h00, "R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule